// File: doc/BRIEF.md
# Condition-Field Vector Predicate Generator

This block turns a bank of 64 four-bit condition fields into a per-element predicate mask for a vector operation. The caller gives a vector length, a three-bit starting group and a choice of which condition bit to test, with an optional complement. Element i reads the condition field whose linear number is the group number times eight, plus i, taken modulo 64. The start point therefore always sits on an eight-field boundary, and the read wraps past field 63 back to field 0. Each condition field holds four flags. From most to least significant they are less-than, greater-than, equal and summary-overflow.

The whole mask is formed combinationally from the current inputs and captured into a result register when `start` is pulsed. From the next cycle on, `mask_valid` stays high and the captured mask is held until the next `start`. The inputs may change freely in the meantime. A lookup port returns the enable bit of one element in the same cycle, so that a datapath can gate its per-element register writes. Elements that are not enabled keep their previous destination value.

The block is plain control rather than a stream: there is no ready input and no back-pressure. A new `start` overwrites the held result regardless of whether anything downstream has consumed it.

Top module: `cfp_predgen`

## Requirements
- R1: After reset, `mask_out` is all zero, `mask_valid` is 0 and `elem_en` is 0 for every index.
- R2: Element i takes its predicate from condition field ((`group_in` × 8) + i) mod 64. Field f occupies bits [4f+3:4f] of `cr_bank`, so field 1 (group 0, element 1) is bits [7:4]. Indices past 63 wrap to 0.
- R3: Every mask bit at a lane index not below the captured vector length is 0.
- R4: `bit_sel` picks the tested flag within the field: 0 is less-than (field bit 3), 1 is greater-than (bit 2), 2 is equal (bit 1) and 3 is summary-overflow (bit 0).
- R5: When `invert` is 1, the selected flag is complemented for lanes below the vector length. Lanes at or above the vector length stay 0.
- R6: A `vl_in` above 64 is treated as 64.
- R7: With `vl_in` equal to 0, the captured mask is all zero and `mask_valid` still rises.
- R8: `mask_valid` is 1 in the cycle after `start` and stays 1. `mask_out` changes only in the cycle after a `start`, however the other inputs move in between.
- R9: `elem_en` equals bit `elem_idx` of the held mask in the same cycle, and is 0 whenever `elem_idx` is not below the captured vector length, including indices 64 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the mask formed from the current inputs |
| vl_in | input | 7 | Vector length, 0 to 64, larger values saturate |
| group_in | input | 3 | Starting group; first field is group × 8 |
| bit_sel | input | 2 | Flag to test: 0 lt, 1 gt, 2 eq, 3 so |
| invert | input | 1 | Complement the selected flag |
| cr_bank | input | 256 | 64 condition fields, field f at bits [4f+3:4f] |
| mask_out | output | 64 | Held predicate mask, bit i for element i |
| mask_valid | output | 1 | High from the cycle after the first start |
| elem_idx | input | 7 | Element index for the lookup port |
| elem_en | output | 1 | Enable for element `elem_idx` |

## Verification
The hardest case to reach is a run that wraps: a high start group whose lanes run past field 63 into the low fields. In that case, a wrong modulo or a missing ×8 scale still yields a plausible mask. The bench covers it by sweeping every group with every flag select and both polarities. It uses vector lengths of 0, 1, 5, 63, 64 and two values above 64, over two bank patterns in which neighbouring fields differ. Straight after each capture it also scrambles the bank and the group, to show that the held mask does not follow the inputs.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam int CFP_FIELDS  = 64;
  localparam int CFP_FIELD_W = 4;
  localparam int CFP_STRIDE  = 8;

  typedef enum logic [1:0] {
    FLAG_LT = 2'd0,
    FLAG_GT = 2'd1,
    FLAG_EQ = 2'd2,
    FLAG_SO = 2'd3
  } flag_sel_e;
endpackage

// File: rtl/cfp_lane_select.sv
module cfp_lane_select #(
  parameter int NFIELDS = cfp_pkg::CFP_FIELDS,
  parameter int FIELD_W = cfp_pkg::CFP_FIELD_W,
  parameter int STRIDE  = cfp_pkg::CFP_STRIDE,
  localparam int IDX_W   = $clog2(NFIELDS),
  localparam int VL_W    = IDX_W + 1,
  localparam int GRP_W   = $clog2(NFIELDS / STRIDE),
  localparam int SHIFT   = $clog2(STRIDE),
  localparam int SEL_W   = $clog2(FIELD_W)
) (
  input  logic [NFIELDS*FIELD_W-1:0] cr_bank_i,
  input  logic [GRP_W-1:0]           group_i,
  input  logic [SEL_W-1:0]           bit_sel_i,
  input  logic                       invert_i,
  input  logic [VL_W-1:0]            vl_i,
  output logic [NFIELDS-1:0]         mask_o
);
  localparam logic [SEL_W-1:0] TOP_BIT = SEL_W'(FIELD_W - 1);

  logic [IDX_W-1:0] base_idx;
  logic [SEL_W-1:0] flag_pos;
  cfp_pkg::flag_sel_e sel_e;

  assign sel_e    = cfp_pkg::flag_sel_e'(bit_sel_i);
  assign base_idx = IDX_W'(group_i) << SHIFT;
  assign flag_pos = TOP_BIT - SEL_W'(sel_e);

  for (genvar i = 0; i < NFIELDS; i++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(i);
    localparam logic [VL_W-1:0]  LANE_VL  = VL_W'(i);
    logic [IDX_W-1:0]   fidx;
    logic [FIELD_W-1:0] fld;
    logic               flag;
    assign fidx      = base_idx + LANE_IDX;
    assign fld       = cr_bank_i[fidx*FIELD_W +: FIELD_W];
    assign flag      = fld[flag_pos] ^ invert_i;
    assign mask_o[i] = flag & (LANE_VL < vl_i);
  end
endmodule

// File: rtl/cfp_mask_reg.sv
module cfp_mask_reg #(
  parameter int NFIELDS = cfp_pkg::CFP_FIELDS,
  localparam int VL_W   = $clog2(NFIELDS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [NFIELDS-1:0] mask_i,
  input  logic [VL_W-1:0]    vl_i,
  output logic [NFIELDS-1:0] mask_q,
  output logic [VL_W-1:0]    vl_q,
  output logic               valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      vl_q    <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      mask_q  <= mask_i;
      vl_q    <= vl_i;
      valid_q <= 1'b1;
    end
  end

  assert_valid_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_q);
  assert_hold_between_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(mask_q) && $stable(vl_q));
endmodule

// File: rtl/cfp_lookup.sv
module cfp_lookup #(
  parameter int NFIELDS = cfp_pkg::CFP_FIELDS,
  localparam int IDX_W  = $clog2(NFIELDS),
  localparam int VL_W   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NFIELDS-1:0] mask_i,
  input  logic [VL_W-1:0]    vl_i,
  input  logic [VL_W-1:0]    idx_i,
  output logic               en_o
);
  logic in_range;
  assign in_range = idx_i < vl_i;
  assign en_o     = in_range & mask_i[idx_i[IDX_W-1:0]];

  assert_lookup_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_i >= vl_i) |-> !en_o);
endmodule

// File: rtl/cfp_predgen.sv
module cfp_predgen #(
  parameter int NFIELDS = cfp_pkg::CFP_FIELDS,
  parameter int FIELD_W = cfp_pkg::CFP_FIELD_W,
  parameter int STRIDE  = cfp_pkg::CFP_STRIDE
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [$clog2(NFIELDS):0]              vl_in,
  input  logic [$clog2(NFIELDS/STRIDE)-1:0]     group_in,
  input  logic [$clog2(FIELD_W)-1:0]            bit_sel,
  input  logic                                  invert,
  input  logic [NFIELDS*FIELD_W-1:0]            cr_bank,
  output logic [NFIELDS-1:0]                    mask_out,
  output logic                                  mask_valid,
  input  logic [$clog2(NFIELDS):0]              elem_idx,
  output logic                                  elem_en
);
  localparam int VL_W = $clog2(NFIELDS) + 1;
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(NFIELDS);

  logic [VL_W-1:0]    vl_sat;
  logic [VL_W-1:0]    vl_q;
  logic [NFIELDS-1:0] mask_c;

  assign vl_sat = (vl_in > VL_MAX) ? VL_MAX : vl_in;

  cfp_lane_select #(.NFIELDS(NFIELDS), .FIELD_W(FIELD_W), .STRIDE(STRIDE)) u_lanes (
    .cr_bank_i (cr_bank),
    .group_i   (group_in),
    .bit_sel_i (bit_sel),
    .invert_i  (invert),
    .vl_i      (vl_sat),
    .mask_o    (mask_c)
  );

  cfp_mask_reg #(.NFIELDS(NFIELDS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .mask_i  (mask_c),
    .vl_i    (vl_sat),
    .mask_q  (mask_out),
    .vl_q    (vl_q),
    .valid_q (mask_valid)
  );

  cfp_lookup #(.NFIELDS(NFIELDS)) u_lookup (
    .clk   (clk),
    .rst_n (rst_n),
    .mask_i(mask_out),
    .vl_i  (vl_q),
    .idx_i (elem_idx),
    .en_o  (elem_en)
  );

  logic [NFIELDS-1:0] live_lanes;
  always_comb begin
    for (int k = 0; k < NFIELDS; k++) live_lanes[k] = (VL_W'(k) < vl_q);
  end

  assert_no_lane_past_vl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_out & ~live_lanes) == '0);
  assert_vl_saturated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= VL_MAX);
  assert_empty_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && vl_in == '0) |=> (mask_out == '0) && mask_valid);
endmodule

// File: tb/tb_cfp_predgen.sv
module tb_cfp_predgen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [6:0]   vl_in = '0;
  logic [2:0]   group_in = '0;
  logic [1:0]   bit_sel = '0;
  logic         invert = 1'b0;
  logic [255:0] cr_bank = '0;
  logic [63:0]  mask_out;
  logic         mask_valid;
  logic [6:0]   elem_idx = '0;
  logic         elem_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfp_predgen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .group_in(group_in),
    .bit_sel(bit_sel), .invert(invert), .cr_bank(cr_bank), .mask_out(mask_out),
    .mask_valid(mask_valid), .elem_idx(elem_idx), .elem_en(elem_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] make_bank(input int seed);
    logic [255:0] b;
    for (int f = 0; f < 64; f++) b[f*4 +: 4] = 4'(f*5 + seed*3 + (f >> 2));
    if (seed[0]) b = ~b;
    return b;
  endfunction

  function automatic logic [63:0] model(input logic [255:0] b, input int g,
                                        input int sel, input bit inv, input int vl);
    logic [63:0] m = '0;
    int len = (vl > 64) ? 64 : vl;
    for (int i = 0; i < len; i++) begin
      int f = (g*8 + i) % 64;
      m[i] = b[f*4 + (3 - sel)] ^ inv;
    end
    return m;
  endfunction

  task automatic run_one(input int g, input int sel, input bit inv, input int vl,
                         input int seed, input bit sweep);
    logic [63:0] exp;
    logic [63:0] held;
    int len;
    @(negedge clk);
    cr_bank = make_bank(seed); group_in = 3'(g); bit_sel = 2'(sel);
    invert = inv; vl_in = 7'(vl); start = 1'b1;
    exp = model(cr_bank, g, sel, inv, vl);
    @(negedge clk);
    start = 1'b0;
    // R2 R4 R5 R6 R7 mapping, flag select, polarity, saturation, empty vector
    chk(mask_out == exp, "R2/R4/R5/R6 mask", mask_out, exp);
    chk(mask_valid == 1'b1, "R8 valid after start", 64'(mask_valid), 64'd1);
    if (vl == 0) chk(mask_out == '0, "R7 empty mask", mask_out, 64'd0);
    held = mask_out;
    cr_bank = ~cr_bank; group_in = group_in ^ 3'd5; invert = ~invert; vl_in = 7'd33;
    @(negedge clk);
    chk(mask_out == held, "R8 hold without start", mask_out, held);
    chk(mask_valid == 1'b1, "R8 valid stays high", 64'(mask_valid), 64'd1);
    if (sweep) begin
      len = (vl > 64) ? 64 : vl;
      for (int k = 0; k < 128; k++) begin
        logic e;
        elem_idx = 7'(k);
        #1;
        e = (k < len) ? held[k % 64] : 1'b0;
        chk(elem_en == e, "R9 lookup", 64'(elem_en), 64'(e));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int vls[7] = '{0, 1, 5, 63, 64, 65, 127};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mask_out == '0, "R1 reset mask", mask_out, 64'd0);
    chk(mask_valid == 1'b0, "R1 reset valid", 64'(mask_valid), 64'd0);
    for (int k = 0; k < 128; k += 9) begin
      elem_idx = 7'(k);
      #1;
      chk(elem_en == 1'b0, "R1 reset lookup", 64'(elem_en), 64'd0);
    end
    // R2 field 1 is linear index 1: group 0, element 1 reads bits [7:4]
    @(negedge clk);
    cr_bank = '0; cr_bank[7] = 1'b1; group_in = 3'd0; bit_sel = 2'd0;
    invert = 1'b0; vl_in = 7'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mask_out == 64'h2, "R2 field one", mask_out, 64'h2);
    // R2 wrap: group 7 element 8 reads field 0
    @(negedge clk);
    cr_bank = '0; cr_bank[3] = 1'b1; group_in = 3'd7; vl_in = 7'd64; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mask_out == 64'h100, "R2 wrap to field zero", mask_out, 64'h100);
    // R3 R5 inverted all-zero bank with short length
    @(negedge clk);
    cr_bank = '0; group_in = 3'd3; invert = 1'b1; vl_in = 7'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mask_out == 64'h3ff, "R3/R5 invert gated by length", mask_out, 64'h3ff);
    // Sweep
    for (int seed = 0; seed < 2; seed++)
      for (int g = 0; g < 8; g++)
        for (int sel = 0; sel < 4; sel++)
          for (int inv = 0; inv < 2; inv++)
            for (int v = 0; v < 7; v++)
              run_one(g, sel, inv[0], vls[v], seed, (sel == 0 && inv == 0));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule